// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This combinational unit returns the smaller or the larger of two floating-point operands. Both operands arrive in 64-bit register format. A double-precision operand uses all 64 bits. A single-precision operand sits in the low 32 bits and must carry all ones in the upper half; this is called NaN-boxing. An operand whose upper half is not all ones is replaced by the canonical quiet NaN before any comparison is made. The two values are ordered with a quiet comparison, so only signaling NaNs raise the invalid flag. The unit then applies a fixed set of NaN rules and drives either the chosen operand or the canonical NaN. Single-precision results are boxed again on the way out.

The unit sits in the execute stage of a floating-point pipeline. It is driven by the operand read ports, a min/max select and a precision select. Its result goes to the register write-back path. Its invalid flag goes to whatever accumulates exception flags downstream.

Top module: `fpmm_minmax`

## Requirements
- R1: With max_sel_i=0 and neither operand NaN, the result is operand A when A is strictly less than B; otherwise it is operand B.
- R2: With max_sel_i=1 and neither operand NaN, the result is operand A when B is less than or equal to A; otherwise it is operand B.
- R3: When exactly one operand is a quiet NaN and no signaling NaN is present, the result is the other operand and invalid_o is 0.
- R4: When both operands are NaN, the result is the canonical NaN of the selected precision. For double this is 0x7FF8000000000000. For single it is 0x7FC00000 in bits 31:0.
- R5: When either operand is a signaling NaN, invalid_o is 1 and the result is the canonical NaN. A signaling NaN has an all-ones exponent, a non-zero fraction and a clear fraction MSB.
- R6: With dbl_i=0, an operand whose bits 63:32 are not all ones behaves exactly as the quiet NaN 0x7FC00000. It does not raise invalid_o.
- R7: With dbl_i=0, bits 63:32 of the result are all ones. With dbl_i=1, the result is the 64-bit value unchanged.
- R8: Zeros of either sign compare equal. Minimum of two zeros returns operand B, and maximum of two zeros returns operand A.
- R9: Ordering follows sign-magnitude rules. Any negative value is below any positive value. Among negatives, the larger magnitude is lower. Infinities are the extremes.
- R10: invalid_o is 0 whenever no operand is a signaling NaN, including when quiet NaNs are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 64 | Operand A in register format |
| opb_i | input | 64 | Operand B in register format |
| max_sel_i | input | 1 | 0 selects minimum, 1 selects maximum |
| dbl_i | input | 1 | 1 selects double precision, 0 selects single |
| res_o | output | 64 | Selected value or canonical NaN, single results boxed |
| invalid_o | output | 1 | Invalid-operation flag, raised by signaling NaNs |

## Verification
The unit is driven with plain finite values of both signs, infinities, and zeros of opposite sign. These cases separate a true sign-magnitude ordering from an unsigned or two's-complement comparison. They also pin down which operand wins a tie. Quiet NaNs in one or both positions separate the pass-through rule from canonical substitution. Signaling NaNs separate the invalid flag from the quiet case. Single operands with broken boxing show whether unboxing happens before classification. A full cross of a value set for both modes and both precisions is compared against an order-key reference model.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int FLEN   = 64;
  localparam int SLEN   = 32;
  localparam int S_EXP  = 8;
  localparam int S_FRAC = 23;
  localparam int D_EXP  = 11;
  localparam int D_FRAC = 52;
  localparam int MAG_W  = FLEN - 1;

  localparam logic [SLEN-1:0] S_QNAN = {1'b0, {S_EXP{1'b1}}, 1'b1, {(S_FRAC-1){1'b0}}};
  localparam logic [FLEN-1:0] D_QNAN = {1'b0, {D_EXP{1'b1}}, 1'b1, {(D_FRAC-1){1'b0}}};

  // Unboxed operand seen as sign plus zero-extended magnitude.
  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             nan;
    logic             snan;
    logic             zero;
  } fp_view_t;

  function automatic logic [FLEN-1:0] canon_nan(input logic dbl);
    return dbl ? D_QNAN : {{(FLEN-SLEN){1'b1}}, S_QNAN};
  endfunction

  // Rebuild a register value from a view, boxing single results.
  function automatic logic [FLEN-1:0] pack_view(input fp_view_t v, input logic dbl);
    return dbl ? {v.sign, v.mag}
               : {{(FLEN-SLEN){1'b1}}, v.sign, v.mag[SLEN-2:0]};
  endfunction

  // Strict less-than on two non-NaN sign-magnitude values.
  function automatic logic sm_less(input fp_view_t x, input fp_view_t y);
    if (x.zero && y.zero)  return 1'b0;
    if (x.sign != y.sign)  return x.sign;
    if (!x.sign)           return x.mag < y.mag;
    return x.mag > y.mag;
  endfunction
endpackage

// File: rtl/fpmm_unpack.sv
module fpmm_unpack
  import fpmm_pkg::*;
(
  input  logic [FLEN-1:0] raw_i,
  input  logic            dbl_i,
  output fp_view_t        view_o,
  output logic            boxed_o
);
  logic [SLEN-1:0] s_val;
  logic            exp_ones, frac_nz, frac_msb;

  assign boxed_o = &raw_i[FLEN-1:SLEN];
  assign s_val   = boxed_o ? raw_i[SLEN-1:0] : S_QNAN;

  always_comb begin
    if (dbl_i) begin
      exp_ones   = &raw_i[FLEN-2 -: D_EXP];
      frac_nz    = |raw_i[D_FRAC-1:0];
      frac_msb   = raw_i[D_FRAC-1];
      view_o.sign = raw_i[FLEN-1];
      view_o.mag  = raw_i[MAG_W-1:0];
    end else begin
      exp_ones   = &s_val[SLEN-2 -: S_EXP];
      frac_nz    = |s_val[S_FRAC-1:0];
      frac_msb   = s_val[S_FRAC-1];
      view_o.sign = s_val[SLEN-1];
      view_o.mag  = {{(MAG_W-SLEN+1){1'b0}}, s_val[SLEN-2:0]};
    end
    view_o.nan  = exp_ones && frac_nz;
    view_o.snan = exp_ones && frac_nz && !frac_msb;
    view_o.zero = (view_o.mag == '0);
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
(
  input  fp_view_t a_i,
  input  fp_view_t b_i,
  output logic     a_lt_b_o,
  output logic     b_le_a_o
);
  logic any_nan, equal;

  assign any_nan = a_i.nan || b_i.nan;
  assign equal   = (a_i.zero && b_i.zero) ||
                   (a_i.sign == b_i.sign && a_i.mag == b_i.mag);

  // Quiet compare: NaN makes every relation false.
  assign a_lt_b_o = !any_nan && sm_less(a_i, b_i);
  assign b_le_a_o = !any_nan && (equal || sm_less(b_i, a_i));

  always_comb begin
    p_order_exclusive_r1: assert (!(a_lt_b_o && b_le_a_o))
      else $error("order outputs both set");
    if (!any_nan && a_i.zero && b_i.zero)
      p_zeros_equal_r8: assert (b_le_a_o && !a_lt_b_o)
        else $error("signed zeros not equal");
  end
endmodule

// File: rtl/fpmm_minmax.sv
module fpmm_minmax
  import fpmm_pkg::*;
(
  input  logic [63:0] opa_i,
  input  logic [63:0] opb_i,
  input  logic        max_sel_i,
  input  logic        dbl_i,
  output logic [63:0] res_o,
  output logic        invalid_o
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][FLEN-1:0] ops;
  fp_view_t                  view_w [NOPS];
  logic     [NOPS-1:0]       boxed_w;
  logic                      a_lt_b, b_le_a, pick_a, both_nan, force_canon;

  assign ops = {opb_i, opa_i};

  for (genvar g = 0; g < NOPS; g++) begin : g_unpack
    fpmm_unpack u_unpack (
      .raw_i  (ops[g]),
      .dbl_i  (dbl_i),
      .view_o (view_w[g]),
      .boxed_o(boxed_w[g])
    );
  end

  fpmm_order u_order (
    .a_i     (view_w[0]),
    .b_i     (view_w[1]),
    .a_lt_b_o(a_lt_b),
    .b_le_a_o(b_le_a)
  );

  always_comb begin
    if (view_w[1].nan)      pick_a = 1'b1;
    else if (view_w[0].nan) pick_a = 1'b0;
    else                    pick_a = max_sel_i ? b_le_a : a_lt_b;
  end

  assign both_nan    = view_w[0].nan && view_w[1].nan;
  assign invalid_o   = view_w[0].snan || view_w[1].snan;
  assign force_canon = both_nan || invalid_o;
  assign res_o       = force_canon ? canon_nan(dbl_i)
                                   : pack_view(pick_a ? view_w[0] : view_w[1], dbl_i);

  always_comb begin
    if (invalid_o)
      p_canon_on_invalid_r5: assert (res_o == canon_nan(dbl_i))
        else $error("invalid without canonical NaN");
    if (both_nan)
      p_two_nan_canon_r4: assert (res_o == canon_nan(dbl_i))
        else $error("two NaNs without canonical NaN");
    if (!dbl_i)
      p_single_boxed_r7: assert (&res_o[63:32])
        else $error("single result not boxed");
    if (view_w[0].nan && !view_w[1].nan && !invalid_o)
      p_nan_yields_other_r3: assert (res_o == pack_view(view_w[1], dbl_i))
        else $error("quiet NaN did not yield other operand");
    if (!dbl_i && !boxed_w[0] && !boxed_w[1])
      p_badbox_canon_r6: assert (res_o == canon_nan(1'b0) && !invalid_o)
        else $error("broken boxing not treated as NaN");
  end
endmodule

// File: tb/test_fpmm_minmax.sv
module test_fpmm_minmax;
  logic        clk = 1'b0;
  logic [63:0] opa, opb, res;
  logic        mx, dbl, inv;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fpmm_minmax i_fpmm_minmax (
    .opa_i(opa), .opb_i(opb), .max_sel_i(mx), .dbl_i(dbl),
    .res_o(res), .invalid_o(inv)
  );

  localparam logic [63:0] BX   = 64'hFFFFFFFF_00000000;
  localparam logic [63:0] DQN  = 64'h7FF8000000000000;
  localparam logic [63:0] SQN  = 64'hFFFFFFFF_7FC00000;

  // Reference: map each value onto a signed order key.
  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic m,
                       input logic d, output logic [63:0] r, output logic fl);
    logic [63:0] ua, ub;
    logic na, nb, sa, sb, take_a;
    longint ka, kb;
    if (d) begin
      ua = a; ub = b;
      na = (a[62:52] == 11'h7FF) && (a[51:0] != 0); sa = na && !a[51];
      nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0); sb = nb && !b[51];
      ka = a[63] ? -longint'({1'b0, a[62:0]}) : longint'({1'b0, a[62:0]});
      kb = b[63] ? -longint'({1'b0, b[62:0]}) : longint'({1'b0, b[62:0]});
    end else begin
      ua = (a[63:32] == 32'hFFFFFFFF) ? a : SQN;
      ub = (b[63:32] == 32'hFFFFFFFF) ? b : SQN;
      na = (ua[30:23] == 8'hFF) && (ua[22:0] != 0); sa = na && !ua[22];
      nb = (ub[30:23] == 8'hFF) && (ub[22:0] != 0); sb = nb && !ub[22];
      ka = ua[31] ? -longint'(ua[30:0]) : longint'(ua[30:0]);
      kb = ub[31] ? -longint'(ub[30:0]) : longint'(ub[30:0]);
    end
    if (na || nb) take_a = nb;
    else          take_a = m ? (kb <= ka) : (ka < kb);
    fl = sa || sb;
    if ((na && nb) || fl) r = d ? DQN : SQN;
    else                  r = take_a ? ua : ub;
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input logic m, input logic d);
    @(negedge clk);
    opa = a; opb = b; mx = m; dbl = d;
    #5;
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] a, input logic [63:0] b,
                     input logic m, input logic d, input logic [63:0] er, input logic ei);
    drive(a, b, m, d);
    chk(tag, res, er);
    chk({tag, " flag"}, {63'd0, inv}, {63'd0, ei});
  endtask

  task automatic t_idle;
    drive(64'd0, 64'd0, 1'b0, 1'b1);
    chk("R8 idle zeros", res, 64'd0);
    chk("R10 idle flag", {63'd0, inv}, 64'd0);
  endtask

  task automatic t_ordinary;
    run("R1 min 1,2",  64'h3FF0000000000000, 64'h4000000000000000, 0, 1, 64'h3FF0000000000000, 0);
    run("R1 min 2,1",  64'h4000000000000000, 64'h3FF0000000000000, 0, 1, 64'h3FF0000000000000, 0);
    run("R2 max 1,2",  64'h3FF0000000000000, 64'h4000000000000000, 1, 1, 64'h4000000000000000, 0);
    run("R1 smin 2,1", BX | 64'h40000000, BX | 64'h3F800000, 0, 0, BX | 64'h3F800000, 0);
  endtask

  task automatic t_negative;
    run("R9 min -3,1",    64'hC008000000000000, 64'h3FF0000000000000, 0, 1, 64'hC008000000000000, 0);
    run("R9 max -3,-inf", 64'hC008000000000000, 64'hFFF0000000000000, 1, 1, 64'hC008000000000000, 0);
    run("R9 min -3,-inf", 64'hC008000000000000, 64'hFFF0000000000000, 0, 1, 64'hFFF0000000000000, 0);
    run("R9 max inf,2",   64'h7FF0000000000000, 64'h4000000000000000, 1, 1, 64'h7FF0000000000000, 0);
  endtask

  task automatic t_zeros;
    run("R8 min +0,-0", 64'd0, 64'h8000000000000000, 0, 1, 64'h8000000000000000, 0);
    run("R8 max +0,-0", 64'd0, 64'h8000000000000000, 1, 1, 64'd0, 0);
  endtask

  task automatic t_one_nan;
    run("R3 min qnan,2",  DQN, 64'h4000000000000000, 0, 1, 64'h4000000000000000, 0);
    run("R3 R10 max 2,qnan", 64'h4000000000000000, 64'h7FF8000000000123, 1, 1, 64'h4000000000000000, 0);
  endtask

  task automatic t_two_nan;
    run("R4 dbl nans", 64'h7FF8000000000005, 64'hFFF8000000000009, 0, 1, DQN, 0);
    run("R4 sgl nans", BX | 64'h7FC00011, BX | 64'hFFC00000, 1, 0, SQN, 0);
  endtask

  task automatic t_snan;
    run("R5 dbl snan", 64'h7FF4000000000000, 64'h3FF0000000000000, 0, 1, DQN, 1);
    run("R5 sgl snan", BX | 64'h3F800000, BX | 64'h7FA00000, 1, 0, SQN, 1);
  endtask

  task automatic t_badbox;
    run("R6 bad A",  64'h00000000_3F800000, BX | 64'h40000000, 0, 0, BX | 64'h40000000, 0);
    run("R6 bad both", 64'h12345678_3F800000, 64'h0000FFFF_40000000, 1, 0, SQN, 0);
  endtask

  task automatic t_boxing;
    run("R7 sgl max", BX | 64'hC0000000, BX | 64'h3F800000, 1, 0, BX | 64'h3F800000, 0);
    run("R7 dbl max", 64'h3FF0000000000000, 64'hC008000000000000, 1, 1, 64'h3FF0000000000000, 0);
  endtask

  task automatic t_sweep;
    logic [63:0] dv [8];
    logic [63:0] sv [8];
    logic [63:0] er;
    logic        ef;
    dv = '{64'h0, 64'h8000000000000000, 64'h3FF0000000000000, 64'hC008000000000000,
           64'h7FF0000000000000, 64'hFFF0000000000000, DQN, 64'h7FF4000000000000};
    sv = '{BX, BX | 64'h80000000, BX | 64'h3F800000, BX | 64'hC0000000,
           BX | 64'h7F800000, 64'h00000000_3F800000, SQN, BX | 64'h7FA00000};
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 2; m++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            logic [63:0] a, b;
            a = d[0] ? dv[i] : sv[i];
            b = d[0] ? dv[j] : sv[j];
            model(a, b, m[0], d[0], er, ef);
            drive(a, b, m[0], d[0]);
            chk("R1 R2 sweep", res, er);
            chk("R5 R10 sweep flag", {63'd0, inv}, {63'd0, ef});
          end
  endtask

  initial begin
    opa = '0; opb = '0; mx = 1'b0; dbl = 1'b1;
    repeat (2) @(posedge clk);
    t_idle;
    t_ordinary;
    t_negative;
    t_zeros;
    t_one_nan;
    t_two_nan;
    t_snan;
    t_badbox;
    t_boxing;
    t_sweep;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule